// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block owns the interrupt side of a small Ethernet MAC. It latches four event sources into a raw status register and holds a matching enable register. Software reads and writes both over a single-cycle register port, clearing raw bits by writing ones. The block drives one level interrupt line.

The receive path has two sources. The first is a plain ready flag that follows the "frames waiting" level from the receive queue. The second is batched: it counts arriving frames and runs an idle timer that restarts on every arrival. It raises a multi-frame flag when either the count reaches a programmed threshold, or the timer expires with frames still outstanding. This lets software take one interrupt per burst instead of one per frame. Two transmit sources cover the rest: a per-packet completion pulse, and the moment the transmit queue occupancy drains to zero.

The interrupt line is gated at three levels: a per-source enable, a port enable and a global enable.

Top module: `rx_coalesce_irq`

## Requirements
- R1: After reset the raw status reads 0, the enable register reads 0, the coalescing word reads 0x08000074 (threshold 8, timer 0x74) and `irq_out` is low.
- R2: A write to address 0 clears each raw bit whose data bit is 1 and leaves bits written 0 unchanged. Bits 5:2 and 31:8 of the raw status always read 0.
- R3: Raw bit 0 (single receive-ready) is set at every clock edge where `rx_waiting` is high. A clearing write has no lasting effect while `rx_waiting` stays high.
- R4: A `tx_done` pulse sets raw bit 1 (transmit per-packet) at the same edge.
- R5: Raw bit 6 (transmit empty) is set one edge after the edge where `tx_level` was sampled nonzero and is now zero. An occupancy that stays at zero does not set it.
- R6: Raw bit 7 (multi-frame receive-ready) is set at the edge whose `rx_frame_in` pulse brings the pending-frame count up to the threshold in coalescing bits 31:24.
- R7: With frames pending and the threshold not reached, raw bit 7 is set T+1 edges after the last arrival, where T is coalescing bits 23:0. Each arrival restarts this interval.
- R8: Clearing raw bit 7 resets the pending count to 0. A frame arriving in the same cycle as that clear counts as the first frame of the new batch. On every raw bit, a set event in the same cycle as a clearing write wins.
- R9: `irq_out` is high exactly when some raw bit and its enable in bits 7:0 of address 1 are both set, and enable bits 18 (port) and 19 (global) are both set.
- R10: The enable register (address 1) stores only bits 7:0, 18 and 19, and the rest read 0. The coalescing register (address 2) stores all 32 bits. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register select: 0 raw status, 1 enable, 2 coalescing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rx_frame_in | input | 1 | One-cycle pulse per received frame |
| rx_waiting | input | 1 | High while any received frame awaits software |
| tx_done | input | 1 | One-cycle pulse per transmitted packet |
| tx_level | input | LVL_W | Transmit queue occupancy |
| irq_out | output | 1 | Interrupt request |

## Verification
The critical overlap is a software clear of the multi-frame flag landing in the same cycle as a new frame arrival, and a clear of the per-packet flag landing with a fresh `tx_done`. The bench drives the write strobe and both event inputs on one cycle, with a threshold of 2. It then expects the multi-frame flag to read clear and the transmit flag to stay set. One further frame must raise the multi-frame flag again, which shows that the overlapping arrival was kept as the first count of the new batch.

// File: rtl/rx_coalesce_irq.sv
`timescale 1ns/1ps
module rx_coalesce_irq #(
  parameter int DW = 32,
  parameter int LVL_W = 6,
  parameter int THR_W = 8,
  parameter logic [THR_W-1:0] THR_RST = 8'd8,
  parameter logic [DW-THR_W-1:0] TMR_RST = 24'h74
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             rx_frame_in,
  input  logic             rx_waiting,
  input  logic             tx_done,
  input  logic [LVL_W-1:0] tx_level,
  output logic             irq_out
);
  localparam int TMR_W = DW - THR_W;
  localparam int PORT_BIT = 18;
  localparam int GLB_BIT = 19;
  localparam logic [1:0] A_RAW = 2'd0;
  localparam logic [1:0] A_EN = 2'd1;
  localparam logic [1:0] A_CFG = 2'd2;
  localparam logic [7:0] RAW_MASK = 8'hC3;

  logic [7:0]       raw_q, src_en_q, clr, set_vec;
  logic             port_en_q, glb_en_q;
  logic [THR_W-1:0] thr_q, frm_cnt, base_cnt, nxt_cnt;
  logic [TMR_W-1:0] tmr_q, idle_q, idle_nxt;
  logic [LVL_W-1:0] tx_prev;
  logic             hit_thr, tmr_fire, tx_empty_evt;
  logic [DW-1:0]    en_word;

  wire wr_raw = reg_wr && (reg_addr == A_RAW);
  wire wr_en  = reg_wr && (reg_addr == A_EN);
  wire wr_cfg = reg_wr && (reg_addr == A_CFG);

  assign clr = wr_raw ? reg_wdata[7:0] : 8'h00;

  always_comb begin
    base_cnt = clr[7] ? '0 : frm_cnt;
    nxt_cnt  = base_cnt;
    if (rx_frame_in && (base_cnt != '1)) nxt_cnt = base_cnt + 1'b1;
  end

  assign hit_thr  = (nxt_cnt != '0) && (nxt_cnt >= thr_q);
  assign tmr_fire = !clr[7] && !rx_frame_in && (frm_cnt != '0) && (idle_q == tmr_q);
  assign tx_empty_evt = (tx_prev != '0) && (tx_level == '0);

  always_comb begin
    idle_nxt = idle_q;
    if (rx_frame_in || clr[7]) idle_nxt = '0;
    else if ((frm_cnt != '0) && (idle_q != tmr_q)) idle_nxt = idle_q + 1'b1;
  end

  assign set_vec = {hit_thr | tmr_fire, tx_empty_evt, 4'b0000, tx_done, rx_waiting};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      frm_cnt <= '0;
      idle_q  <= '0;
      tx_prev <= '0;
    end else begin
      raw_q   <= (set_vec | (raw_q & ~clr)) & RAW_MASK;
      frm_cnt <= nxt_cnt;
      idle_q  <= idle_nxt;
      tx_prev <= tx_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en_q  <= '0;
      port_en_q <= 1'b0;
      glb_en_q  <= 1'b0;
      thr_q     <= THR_RST;
      tmr_q     <= TMR_RST;
    end else begin
      if (wr_en) begin
        src_en_q  <= reg_wdata[7:0];
        port_en_q <= reg_wdata[PORT_BIT];
        glb_en_q  <= reg_wdata[GLB_BIT];
      end
      if (wr_cfg) {thr_q, tmr_q} <= reg_wdata;
    end
  end

  always_comb begin
    en_word = '0;
    en_word[7:0] = src_en_q;
    en_word[PORT_BIT] = port_en_q;
    en_word[GLB_BIT] = glb_en_q;
  end

  always_comb begin
    case (reg_addr)
      A_RAW:   reg_rdata = {{(DW-8){1'b0}}, raw_q};
      A_EN:    reg_rdata = en_word;
      A_CFG:   reg_rdata = {thr_q, tmr_q};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_out = glb_en_q & port_en_q & (|(raw_q & src_en_q));
endmodule

module rx_coalesce_irq_chk #(
  parameter int DW = 32,
  parameter int LVL_W = 6,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             rx_frame_in,
  input logic             rx_waiting,
  input logic             tx_done,
  input logic [LVL_W-1:0] tx_level,
  input logic             irq_out,
  input logic [7:0]       raw_q,
  input logic [THR_W-1:0] frm_cnt
);
  a_r2_w1c_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[1] && !tx_done) |=> !raw_q[1]);
  a_r3_rx_wait_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_waiting |=> raw_q[0]);
  a_r4_tx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> raw_q[1]);
  a_r5_empty_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0 && $past(tx_level) != '0) |=> raw_q[6]);
  a_r8_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[7] && !rx_frame_in) |=> (frm_cnt == '0));
  a_r9_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (raw_q != 8'h00));
endmodule

bind rx_coalesce_irq rx_coalesce_irq_chk #(.DW(DW), .LVL_W(LVL_W), .THR_W(THR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rx_frame_in(rx_frame_in), .rx_waiting(rx_waiting), .tx_done(tx_done), .tx_level(tx_level),
  .irq_out(irq_out), .raw_q(raw_q), .frm_cnt(frm_cnt));

// File: tb/rx_coalesce_irq_tb.sv
`timescale 1ns/1ps
module rx_coalesce_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_frame_in = 1'b0;
  logic        rx_waiting = 1'b0;
  logic        tx_done = 1'b0;
  logic [5:0]  tx_level = '0;
  logic        irq_out;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_coalesce_irq dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_frame_in(rx_frame_in),
    .rx_waiting(rx_waiting), .tx_done(tx_done), .tx_level(tx_level), .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic frame();
    @(negedge clk); rx_frame_in = 1'b1;
    @(negedge clk); rx_frame_in = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 raw", v, 32'h0);
    rd(2'd1, v); check("R1 enable", v, 32'h0);
    rd(2'd2, v); check("R1 coalesce", v, 32'h0800_0074);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R10 enable mask", v, 32'h000C_00FF);
    wr(2'd2, 32'h0300_000A); rd(2'd2, v); check("R10 coalesce", v, 32'h0300_000A);
    rd(2'd3, v); check("R10 addr3", v, 32'h0);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_tx_done();
    logic [31:0] v;
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    rd(2'd0, v); check("R4 tx_done sets bit1", v, 32'h2);
    wr(2'd0, 32'hFFFF_FF3C); rd(2'd0, v); check("R2 zero write keeps bit1", v, 32'h2);
    wr(2'd0, 32'h2); rd(2'd0, v); check("R2 w1c bit1", v, 32'h0);
  endtask

  task automatic t_tx_empty();
    logic [31:0] v;
    @(negedge clk); tx_level = 6'd3;
    @(negedge clk); tx_level = 6'd0;
    @(negedge clk); rd(2'd0, v); check("R5 drain sets bit6", v, 32'h40);
    wr(2'd0, 32'h40);
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R5 stay empty no set", v, 32'h0);
  endtask

  task automatic t_rx_wait();
    logic [31:0] v;
    @(negedge clk); rx_waiting = 1'b1;
    @(negedge clk); rd(2'd0, v); check("R3 waiting sets bit0", v, 32'h1);
    wr(2'd0, 32'h1); rd(2'd0, v); check("R3 clear while waiting", v, 32'h1);
    rx_waiting = 1'b0;
    wr(2'd0, 32'h1); rd(2'd0, v); check("R3 clear after drain", v, 32'h0);
  endtask

  task automatic t_thr();
    logic [31:0] v;
    wr(2'd2, {8'd3, 24'd1000});
    frame(); frame();
    rd(2'd0, v); check("R6 below threshold", v, 32'h0);
    frame(); rd(2'd0, v); check("R6 threshold reached", v, 32'h80);
    wr(2'd0, 32'h80);
    frame(); frame();
    rd(2'd0, v); check("R8 count cleared", v, 32'h0);
    frame(); rd(2'd0, v); check("R8 new batch reaches threshold", v, 32'h80);
    wr(2'd0, 32'h80);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    wr(2'd2, {8'd8, 24'd10});
    frame();
    repeat (10) @(negedge clk);
    rd(2'd0, v); check("R7 before expiry", v, 32'h0);
    @(negedge clk); rd(2'd0, v); check("R7 expiry", v, 32'h80);
    wr(2'd0, 32'h80);
    frame();
    repeat (6) @(negedge clk);
    frame();
    repeat (10) @(negedge clk);
    rd(2'd0, v); check("R7 restart not yet", v, 32'h0);
    @(negedge clk); rd(2'd0, v); check("R7 restart expiry", v, 32'h80);
    wr(2'd0, 32'h80);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(2'd2, {8'd2, 24'd5000});
    frame(); frame();
    rd(2'd0, v); check("R6 threshold 2", v, 32'h80);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h82; rx_frame_in = 1'b1; tx_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; rx_frame_in = 1'b0; tx_done = 1'b0;
    rd(2'd0, v); check("R8 clear with arrival and set-wins", v, 32'h02);
    frame(); rd(2'd0, v); check("R8 overlapping arrival counted", v, 32'h82);
    wr(2'd0, 32'hFF);
    rd(2'd0, v); check("R2 all cleared", v, 32'h0);
  endtask

  task automatic t_irq();
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    wr(2'd1, 32'h2); check("R9 no port/global", {31'b0, irq_out}, 32'h0);
    wr(2'd1, 32'h0004_0002); check("R9 no global", {31'b0, irq_out}, 32'h0);
    wr(2'd1, 32'h000C_0002); check("R9 all enables", {31'b0, irq_out}, 32'h1);
    wr(2'd1, 32'h000C_0001); check("R9 other source only", {31'b0, irq_out}, 32'h0);
    wr(2'd1, 32'h000C_0002); wr(2'd0, 32'h2);
    check("R9 raw cleared", {31'b0, irq_out}, 32'h0);
    wr(2'd1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx_done();
    t_tx_empty();
    t_rx_wait();
    t_thr();
    t_timer();
    t_same_cycle();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule